// File: doc/BRIEF.md
# Operand Bypass and Pipeline Interlock Controller

This controller sits beside a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback) and decides three things every cycle from register specifiers and per-stage flags. First, it steers the two ALU operand multiplexers in execute. Each operand can come from the register file value latched in decode, from the ALU output held in the execute/memory register, or from the memory/writeback register, where either load data or an ALU result sits.

Second, it detects a load in execute whose destination is read by the instruction in decode. For that case it freezes the program counter and the fetch/decode register, and turns the decode/execute entry into a no-op for one cycle. Third, when the execute/memory register holds a valid taken branch or jump, it squashes the three younger instructions by clearing the valid bits of the fetch/decode, decode/execute and execute/memory registers.

The register file writes early in a cycle and reads late, so no bypass from writeback into decode exists. Register 0 always reads as zero and never takes part in matching. The controller is purely combinational: its outputs follow its inputs within the same cycle.

Top module: `hzd_unit`

## Requirements
- R1: When an operand's source is used, is nonzero and equals the destination of a valid, writing, non-load instruction in the execute/memory register, that operand's select is 2'b01 (execute/memory ALU output). A load there that matches gives select 2'b00 (register value).
- R2: When no execute/memory match exists and the operand's used, nonzero source equals the destination of a valid, writing instruction in the memory/writeback register, the select is 2'b10 if that instruction is a load and 2'b11 otherwise.
- R3: When both the execute/memory and the memory/writeback registers match the same source, the execute/memory entry decides the select.
- R4: A specifier of 0 never matches: operand selects stay 2'b00 and no hold is raised, even if a producer names destination 0.
- R5: A source whose used flag is low never matches: no forwarding for it and no hold from it.
- R6: A valid, writing load in execute whose nonzero destination equals a used source of the instruction in decode raises hold_front and insert_bubble together for that cycle. A non-load or invalid producer in execute raises neither.
- R7: A load that is already in the execute/memory or memory/writeback register and matches a decode source raises no hold.
- R8: A valid taken control transfer in the execute/memory register raises kill_fd, kill_de and kill_em together. A not-taken or invalid entry raises none of them.
- R9: When a squash and a load-use condition occur in the same cycle, the squash wins: all kills are high and hold_front and insert_bubble are low.
- R10: Selects are independent per operand: a match on one source does not change the other operand's select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_rs1 | input | REG_ADDR_W | First source specifier of the instruction in decode |
| dec_rs2 | input | REG_ADDR_W | Second source specifier of the instruction in decode |
| dec_rs1_used | input | 1 | Decode instruction reads its first source |
| dec_rs2_used | input | 1 | Decode instruction reads its second source |
| exe_valid | input | 1 | Decode/execute register holds a live instruction |
| exe_rs1 | input | REG_ADDR_W | First source specifier in execute |
| exe_rs2 | input | REG_ADDR_W | Second source specifier in execute |
| exe_rs1_used | input | 1 | Execute instruction reads its first source |
| exe_rs2_used | input | 1 | Execute instruction reads its second source |
| exe_rd | input | REG_ADDR_W | Destination of the instruction in execute |
| exe_wen | input | 1 | Execute instruction writes a register |
| exe_load | input | 1 | Execute instruction is a load |
| exm_valid | input | 1 | Execute/memory register holds a live instruction |
| exm_rd | input | REG_ADDR_W | Destination held in the execute/memory register |
| exm_wen | input | 1 | Execute/memory instruction writes a register |
| exm_load | input | 1 | Execute/memory instruction is a load |
| exm_taken | input | 1 | Execute/memory instruction is a taken branch or jump |
| mwb_valid | input | 1 | Memory/writeback register holds a live instruction |
| mwb_rd | input | REG_ADDR_W | Destination held in the memory/writeback register |
| mwb_wen | input | 1 | Memory/writeback instruction writes a register |
| mwb_load | input | 1 | Memory/writeback instruction is a load |
| fwd_a | output | 2 | First ALU operand select (00 register, 01 exe/mem ALU, 10 load data, 11 mem/wb ALU) |
| fwd_b | output | 2 | Second ALU operand select, same encoding |
| hold_front | output | 1 | Freeze the PC and the fetch/decode register |
| insert_bubble | output | 1 | Write a no-op into the decode/execute register |
| kill_fd | output | 1 | Clear the fetch/decode valid bit |
| kill_de | output | 1 | Clear the decode/execute valid bit |
| kill_em | output | 1 | Clear the execute/memory valid bit |

## Verification
Every output is a combinational function of the present inputs, so a wrong match, priority or gating shows at the select, hold or kill ports in the same cycle the offending stage contents appear. The bench therefore settles each stage configuration and reads the ports half a period later. Some errors would otherwise stay hidden. A missing register-0 guard would only show with destination 0 present. A swapped priority would only show when both producers name the same register. A hold that escapes a squash would only show with a load-use and a taken branch together. The scenarios build each of these coincidences on purpose.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    typedef enum logic [1:0] {
        OPSEL_RF       = 2'b00,
        OPSEL_EXM_ALU  = 2'b01,
        OPSEL_MWB_LOAD = 2'b10,
        OPSEL_MWB_ALU  = 2'b11
    } opsel_e;

    localparam int unsigned NUM_OPS = 2;

    // Nearer producer wins; a nearer load blocks older values too.
    function automatic opsel_e choose_sel(
        input logic near_hit,
        input logic near_load,
        input logic far_hit,
        input logic far_load
    );
        if (near_hit)
            return near_load ? OPSEL_RF : OPSEL_EXM_ALU;
        else if (far_hit)
            return far_load ? OPSEL_MWB_LOAD : OPSEL_MWB_ALU;
        else
            return OPSEL_RF;
    endfunction

endpackage

// File: rtl/hzd_match.sv
module hzd_match #(
    parameter int unsigned REG_ADDR_W = 5
) (
    input  logic [REG_ADDR_W-1:0] src,
    input  logic                  src_used,
    input  logic                  prod_valid,
    input  logic                  prod_wen,
    input  logic [REG_ADDR_W-1:0] prod_rd,
    output logic                  hit
);
    localparam logic [REG_ADDR_W-1:0] ZERO_REG = '0;

    always_comb begin
        hit = src_used && prod_valid && prod_wen &&
              (prod_rd != ZERO_REG) && (prod_rd == src);
    end
endmodule

// File: rtl/hzd_fwd_sel.sv
module hzd_fwd_sel
    import hzd_pkg::*;
#(
    parameter int unsigned REG_ADDR_W = 5
) (
    input  logic [REG_ADDR_W-1:0] src,
    input  logic                  src_used,
    input  logic                  exm_valid,
    input  logic [REG_ADDR_W-1:0] exm_rd,
    input  logic                  exm_wen,
    input  logic                  exm_load,
    input  logic                  mwb_valid,
    input  logic [REG_ADDR_W-1:0] mwb_rd,
    input  logic                  mwb_wen,
    input  logic                  mwb_load,
    output opsel_e                sel
);
    logic near_hit;
    logic far_hit;

    hzd_match #(.REG_ADDR_W(REG_ADDR_W)) near_m (
        .src(src), .src_used(src_used),
        .prod_valid(exm_valid), .prod_wen(exm_wen), .prod_rd(exm_rd),
        .hit(near_hit)
    );

    hzd_match #(.REG_ADDR_W(REG_ADDR_W)) far_m (
        .src(src), .src_used(src_used),
        .prod_valid(mwb_valid), .prod_wen(mwb_wen), .prod_rd(mwb_rd),
        .hit(far_hit)
    );

    always_comb begin
        sel = choose_sel(near_hit, exm_load, far_hit, mwb_load);
    end
endmodule

// File: rtl/hzd_interlock.sv
module hzd_interlock
    import hzd_pkg::*;
#(
    parameter int unsigned REG_ADDR_W = 5
) (
    input  logic [REG_ADDR_W-1:0] dec_src  [NUM_OPS],
    input  logic                  dec_used [NUM_OPS],
    input  logic                  exe_valid,
    input  logic [REG_ADDR_W-1:0] exe_rd,
    input  logic                  exe_wen,
    input  logic                  exe_load,
    input  logic                  exm_valid,
    input  logic                  exm_taken,
    output logic                  hold,
    output logic                  bubble,
    output logic                  kill_fd,
    output logic                  kill_de,
    output logic                  kill_em
);
    logic [NUM_OPS-1:0] lu_hit;
    logic               squash;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_lu
        hzd_match #(.REG_ADDR_W(REG_ADDR_W)) lu_m (
            .src(dec_src[g]), .src_used(dec_used[g]),
            .prod_valid(exe_valid), .prod_wen(exe_wen), .prod_rd(exe_rd),
            .hit(lu_hit[g])
        );
    end

    always_comb begin
        squash  = exm_valid && exm_taken;
        kill_fd = squash;
        kill_de = squash;
        kill_em = squash;
        hold    = exe_load && (|lu_hit) && !squash;
        bubble  = hold;
    end
endmodule

// File: rtl/hzd_unit.sv
module hzd_unit
    import hzd_pkg::*;
#(
    parameter int unsigned REG_ADDR_W = 5
) (
    input  logic [REG_ADDR_W-1:0] dec_rs1,
    input  logic [REG_ADDR_W-1:0] dec_rs2,
    input  logic                  dec_rs1_used,
    input  logic                  dec_rs2_used,
    input  logic                  exe_valid,
    input  logic [REG_ADDR_W-1:0] exe_rs1,
    input  logic [REG_ADDR_W-1:0] exe_rs2,
    input  logic                  exe_rs1_used,
    input  logic                  exe_rs2_used,
    input  logic [REG_ADDR_W-1:0] exe_rd,
    input  logic                  exe_wen,
    input  logic                  exe_load,
    input  logic                  exm_valid,
    input  logic [REG_ADDR_W-1:0] exm_rd,
    input  logic                  exm_wen,
    input  logic                  exm_load,
    input  logic                  exm_taken,
    input  logic                  mwb_valid,
    input  logic [REG_ADDR_W-1:0] mwb_rd,
    input  logic                  mwb_wen,
    input  logic                  mwb_load,
    output logic [1:0]            fwd_a,
    output logic [1:0]            fwd_b,
    output logic                  hold_front,
    output logic                  insert_bubble,
    output logic                  kill_fd,
    output logic                  kill_de,
    output logic                  kill_em
);
    logic [REG_ADDR_W-1:0] op_src   [NUM_OPS];
    logic                  op_used  [NUM_OPS];
    logic [REG_ADDR_W-1:0] dec_src  [NUM_OPS];
    logic                  dec_used [NUM_OPS];
    opsel_e                op_sel   [NUM_OPS];

    always_comb begin
        op_src[0]   = exe_rs1;
        op_src[1]   = exe_rs2;
        op_used[0]  = exe_rs1_used;
        op_used[1]  = exe_rs2_used;
        dec_src[0]  = dec_rs1;
        dec_src[1]  = dec_rs2;
        dec_used[0] = dec_rs1_used;
        dec_used[1] = dec_rs2_used;
    end

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        hzd_fwd_sel #(.REG_ADDR_W(REG_ADDR_W)) sel_i (
            .src(op_src[g]), .src_used(op_used[g]),
            .exm_valid(exm_valid), .exm_rd(exm_rd),
            .exm_wen(exm_wen), .exm_load(exm_load),
            .mwb_valid(mwb_valid), .mwb_rd(mwb_rd),
            .mwb_wen(mwb_wen), .mwb_load(mwb_load),
            .sel(op_sel[g])
        );
    end

    assign fwd_a = op_sel[0];
    assign fwd_b = op_sel[1];

    hzd_interlock #(.REG_ADDR_W(REG_ADDR_W)) lock_i (
        .dec_src(dec_src), .dec_used(dec_used),
        .exe_valid(exe_valid), .exe_rd(exe_rd),
        .exe_wen(exe_wen), .exe_load(exe_load),
        .exm_valid(exm_valid), .exm_taken(exm_taken),
        .hold(hold_front), .bubble(insert_bubble),
        .kill_fd(kill_fd), .kill_de(kill_de), .kill_em(kill_em)
    );
endmodule

// File: rtl/hzd_unit_chk.sv
module hzd_unit_chk #(
    parameter int unsigned REG_ADDR_W = 5
) (
    input logic [REG_ADDR_W-1:0] exe_rs1,
    input logic [REG_ADDR_W-1:0] exe_rs2,
    input logic                  exe_valid,
    input logic                  exe_load,
    input logic                  exm_load,
    input logic                  exm_wen,
    input logic                  exm_valid,
    input logic                  exm_taken,
    input logic                  mwb_load,
    input logic [1:0]            fwd_a,
    input logic [1:0]            fwd_b,
    input logic                  hold_front,
    input logic                  insert_bubble,
    input logic                  kill_fd,
    input logic                  kill_de,
    input logic                  kill_em
);
    localparam logic [REG_ADDR_W-1:0] ZR = '0;

    always_comb begin
        AST_EXM_FWD_ALU_ONLY: assert (fwd_a != 2'b01 || (!exm_load && exm_wen && exm_valid)); // R1
        AST_LOAD_SEL_NEEDS_LOAD: assert (fwd_b != 2'b10 || mwb_load); // R2
        AST_ZERO_A_STAYS_RF: assert (exe_rs1 != ZR || fwd_a == 2'b00); // R4
        AST_ZERO_B_STAYS_RF: assert (exe_rs2 != ZR || fwd_b == 2'b00); // R4
        AST_HOLD_PAIRS_BUBBLE: assert (hold_front == insert_bubble); // R6
        AST_HOLD_NEEDS_EXE_LOAD: assert (!hold_front || (exe_load && exe_valid)); // R6
        AST_KILLS_TOGETHER: assert (kill_fd == kill_de && kill_de == kill_em); // R8
        AST_KILL_NEEDS_TAKEN: assert (!kill_em || (exm_valid && exm_taken)); // R8
        AST_SQUASH_BEATS_HOLD: assert (!(kill_fd && hold_front)); // R9
    end
endmodule

bind hzd_unit hzd_unit_chk #(.REG_ADDR_W(REG_ADDR_W)) chk_i (
    .exe_rs1(exe_rs1), .exe_rs2(exe_rs2), .exe_valid(exe_valid),
    .exe_load(exe_load), .exm_load(exm_load), .exm_wen(exm_wen),
    .exm_valid(exm_valid), .exm_taken(exm_taken), .mwb_load(mwb_load),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .hold_front(hold_front),
    .insert_bubble(insert_bubble), .kill_fd(kill_fd), .kill_de(kill_de),
    .kill_em(kill_em)
);

// File: tb/hzd_unit_tb_top.sv
`timescale 1ns/1ps
module hzd_unit_tb_top;
    localparam int unsigned W = 5;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [W-1:0] dec_rs1, dec_rs2, exe_rs1, exe_rs2, exe_rd, exm_rd, mwb_rd;
    logic dec_rs1_used, dec_rs2_used, exe_valid, exe_rs1_used, exe_rs2_used;
    logic exe_wen, exe_load, exm_valid, exm_wen, exm_load, exm_taken;
    logic mwb_valid, mwb_wen, mwb_load;
    logic [1:0] fwd_a, fwd_b;
    logic hold_front, insert_bubble, kill_fd, kill_de, kill_em;

    int checks = 0;
    int errors = 0;

    hzd_unit #(.REG_ADDR_W(W)) dut_i (
        .dec_rs1(dec_rs1), .dec_rs2(dec_rs2),
        .dec_rs1_used(dec_rs1_used), .dec_rs2_used(dec_rs2_used),
        .exe_valid(exe_valid), .exe_rs1(exe_rs1), .exe_rs2(exe_rs2),
        .exe_rs1_used(exe_rs1_used), .exe_rs2_used(exe_rs2_used),
        .exe_rd(exe_rd), .exe_wen(exe_wen), .exe_load(exe_load),
        .exm_valid(exm_valid), .exm_rd(exm_rd), .exm_wen(exm_wen),
        .exm_load(exm_load), .exm_taken(exm_taken),
        .mwb_valid(mwb_valid), .mwb_rd(mwb_rd), .mwb_wen(mwb_wen),
        .mwb_load(mwb_load),
        .fwd_a(fwd_a), .fwd_b(fwd_b), .hold_front(hold_front),
        .insert_bubble(insert_bubble), .kill_fd(kill_fd),
        .kill_de(kill_de), .kill_em(kill_em)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic quiet();
        @(posedge clk);
        dec_rs1 = '0; dec_rs2 = '0; dec_rs1_used = 0; dec_rs2_used = 0;
        exe_valid = 0; exe_rs1 = '0; exe_rs2 = '0; exe_rs1_used = 0;
        exe_rs2_used = 0; exe_rd = '0; exe_wen = 0; exe_load = 0;
        exm_valid = 0; exm_rd = '0; exm_wen = 0; exm_load = 0; exm_taken = 0;
        mwb_valid = 0; mwb_rd = '0; mwb_wen = 0; mwb_load = 0;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic t_idle();
        quiet(); settle();
        chk("idle fwd_a", fwd_a, 0);
        chk("idle fwd_b", fwd_b, 0);
        chk("idle hold", hold_front, 0);
        chk("idle kill", kill_fd | kill_de | kill_em, 0);
    endtask

    task automatic t_exm_fwd();
        quiet();
        exe_rs1 = 5; exe_rs1_used = 1; exe_rs2 = 6; exe_rs2_used = 1;
        exm_valid = 1; exm_wen = 1; exm_rd = 5;
        settle();
        chk("R1 exm alu to a", fwd_a, 1);
        chk("R10 b untouched", fwd_b, 0);
        @(posedge clk); exe_rs2 = 5; settle();
        chk("R1 exm alu to b", fwd_b, 1);
        @(posedge clk); exm_load = 1; settle();
        chk("R1 exm load gives rf", fwd_a, 0);
        @(posedge clk); exm_load = 0; exm_wen = 0; settle();
        chk("R1 no wen no fwd", fwd_a, 0);
    endtask

    task automatic t_mwb_fwd();
        quiet();
        exe_rs2 = 7; exe_rs2_used = 1; exe_rs1 = 8; exe_rs1_used = 1;
        mwb_valid = 1; mwb_wen = 1; mwb_rd = 7; mwb_load = 1;
        settle();
        chk("R2 load data to b", fwd_b, 2);
        chk("R10 a untouched", fwd_a, 0);
        @(posedge clk); mwb_load = 0; settle();
        chk("R2 mwb alu to b", fwd_b, 3);
        @(posedge clk); mwb_valid = 0; settle();
        chk("R2 invalid mwb", fwd_b, 0);
    endtask

    task automatic t_priority();
        quiet();
        exe_rs1 = 3; exe_rs1_used = 1;
        exm_valid = 1; exm_wen = 1; exm_rd = 3;
        mwb_valid = 1; mwb_wen = 1; mwb_rd = 3; mwb_load = 1;
        settle();
        chk("R3 exm beats mwb", fwd_a, 1);
        @(posedge clk); exm_load = 1; mwb_load = 0; settle();
        chk("R3 exm load still decides", fwd_a, 0);
    endtask

    task automatic t_zero();
        quiet();
        exe_rs1 = 0; exe_rs1_used = 1; exe_rs2 = 0; exe_rs2_used = 1;
        exm_valid = 1; exm_wen = 1; exm_rd = 0;
        mwb_valid = 1; mwb_wen = 1; mwb_rd = 0;
        dec_rs1 = 0; dec_rs1_used = 1;
        exe_valid = 1; exe_wen = 1; exe_load = 1; exe_rd = 0;
        settle();
        chk("R4 zero a", fwd_a, 0);
        chk("R4 zero b", fwd_b, 0);
        chk("R4 zero no hold", hold_front, 0);
    endtask

    task automatic t_unused();
        quiet();
        exe_rs1 = 9; exe_rs1_used = 0;
        exm_valid = 1; exm_wen = 1; exm_rd = 9;
        dec_rs2 = 4; dec_rs2_used = 0;
        exe_valid = 1; exe_wen = 1; exe_load = 1; exe_rd = 4;
        settle();
        chk("R5 unused no fwd", fwd_a, 0);
        chk("R5 unused no hold", hold_front, 0);
    endtask

    task automatic t_load_use();
        quiet();
        exe_valid = 1; exe_wen = 1; exe_load = 1; exe_rd = 12;
        dec_rs1 = 12; dec_rs1_used = 1;
        settle();
        chk("R6 hold rs1", hold_front, 1);
        chk("R6 bubble rs1", insert_bubble, 1);
        @(posedge clk); dec_rs1 = 1; dec_rs2 = 12; dec_rs2_used = 1; settle();
        chk("R6 hold rs2", hold_front, 1);
        @(posedge clk); exe_load = 0; settle();
        chk("R6 alu producer no hold", hold_front, 0);
        chk("R6 alu producer no bubble", insert_bubble, 0);
        @(posedge clk); exe_load = 1; exe_valid = 0; settle();
        chk("R6 invalid load no hold", hold_front, 0);
    endtask

    task automatic t_far_load();
        quiet();
        dec_rs1 = 14; dec_rs1_used = 1;
        exm_valid = 1; exm_wen = 1; exm_load = 1; exm_rd = 14;
        settle();
        chk("R7 exm load no hold", hold_front, 0);
        @(posedge clk); exm_valid = 0;
        mwb_valid = 1; mwb_wen = 1; mwb_load = 1; mwb_rd = 14; settle();
        chk("R7 mwb load no hold", hold_front, 0);
    endtask

    task automatic t_squash();
        quiet();
        exm_valid = 1; exm_taken = 1;
        settle();
        chk("R8 kill_fd", kill_fd, 1);
        chk("R8 kill_de", kill_de, 1);
        chk("R8 kill_em", kill_em, 1);
        @(posedge clk); exm_taken = 0; settle();
        chk("R8 not taken", kill_fd | kill_de | kill_em, 0);
        @(posedge clk); exm_taken = 1; exm_valid = 0; settle();
        chk("R8 invalid taken", kill_fd | kill_de | kill_em, 0);
    endtask

    task automatic t_squash_over_hold();
        quiet();
        exe_valid = 1; exe_wen = 1; exe_load = 1; exe_rd = 20;
        dec_rs1 = 20; dec_rs1_used = 1;
        exm_valid = 1; exm_taken = 1;
        settle();
        chk("R9 kills win", kill_fd & kill_de & kill_em, 1);
        chk("R9 no hold", hold_front, 0);
        chk("R9 no bubble", insert_bubble, 0);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_idle();
        t_exm_fwd();
        t_mwb_fwd();
        t_priority();
        t_zero();
        t_unused();
        t_load_use();
        t_far_load();
        t_squash();
        t_squash_over_hold();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule